// File: doc/BRIEF.md
# Sub-Pixel Pulse Length Encoder

Three sub-pixel discriminator outputs share one readout channel. The block sends a single digital pulse on that channel, and the length of the pulse tells which sub-pixel fired. Each sub-pixel has a 4-bit length setting, counted in clock cycles. A receiver that measures time over threshold reads the pulse length and maps it back to the sub-pixel whose setting matches. To keep that mapping unique, the lengths must be distinct and non-zero.

The inputs are asynchronous. They pass through a synchronizer, and only a rising edge starts a pulse. When several sub-pixels fire together, the longest configured length wins. A new hit that arrives while a pulse is running can lengthen the pulse but never cut it short. After each pulse the line is forced low for a minimum gap, so that a receiver can separate two pulses. A hit that arrives during that gap is remembered and sent as soon as the gap ends.

Top module: `spl_encoder`

## Requirements
- R1: While reset is high, and after reset until a hit edge reaches the output, `pulse_o` is low.
- R2: A rising edge on hit input i whose length L is non-zero yields exactly one pulse of L cycles. The pulse is first seen high after the third rising clock edge, counting from the first edge that samples the input high.
- R3: A sub-pixel whose length setting is 0 produces no pulse.
- R4: When several hit inputs rise in the same cycle, the pulse length is the largest length among them.
- R5: A rising edge that reaches the pulse logic while a pulse is high, including its last high cycle, keeps the line high until the later of two ends: the old pulse's end, or the new sub-pixel's own pulse end counted from that edge.
- R6: A hit that arrives during a pulse never shortens it.
- R7: After a pulse ends, `pulse_o` stays low for at least GAP_CYCLES cycles (default 2). A hit whose edge lands in that gap starts its pulse on the first cycle after the gap.
- R8: An input held high produces only one pulse.
- R9: Setting `len_cfg_i[4*i +: 4]` for sub-pixel i, with distinct settings, the measured high time of a single-hit pulse equals that setting and so identifies i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_i | input | NUM_SUB (3) | Asynchronous sub-pixel discriminator outputs |
| len_cfg_i | input | NUM_SUB*LEN_W (12) | Per sub-pixel pulse length, sub-pixel i in bits 4*i+3..4*i |
| pulse_o | output | 1 | Registered length-coded output pulse |

## Verification
The bench targets the following corner cases:
- **Coincident hits.** A design that ORs the lengths, or takes the lowest sub-pixel index, gives a wrong length.
- **Hits during a pulse.** Hits arrive early, mid-pulse and on the last high cycle. A design that reloads the counter would cut a long pulse short, and one that ignores the new hit would drop the longer code.
- **Hit just after a pulse ends.** A design without the low gap would merge two pulses, and one that drops gap hits would lose the second pulse.
- **Held input and zero length.** A level-triggered design would repeat pulses on a held input. A zero-length sub-pixel that still fired would emit a one-cycle pulse.

// File: rtl/spl_pkg.sv
package spl_pkg;
  localparam int unsigned DEF_NUM_SUB = 3;
  localparam int unsigned DEF_LEN_W   = 4;
  localparam int unsigned DEF_SYNC    = 2;
  localparam int unsigned DEF_GAP     = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_GAP  = 2'd2
  } line_state_e;
endpackage

// File: rtl/spl_edge_sync.sv
module spl_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  AST_EDGE_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R8
endmodule

// File: rtl/spl_max_sel.sv
module spl_max_sel #(
  parameter int unsigned NUM_SUB = 3,
  parameter int unsigned LEN_W   = 4
) (
  input  logic [NUM_SUB-1:0]       rise_i,
  input  logic [NUM_SUB*LEN_W-1:0] len_i,
  output logic [LEN_W-1:0]         max_o
);
  logic [LEN_W-1:0] stage [NUM_SUB+1];

  assign stage[0] = '0;

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_cmp
    logic [LEN_W-1:0] cand;
    assign cand         = rise_i[g] ? len_i[g*LEN_W +: LEN_W] : '0;
    assign stage[g + 1] = (cand > stage[g]) ? cand : stage[g];
  end

  assign max_o = stage[NUM_SUB];
endmodule

// File: rtl/spl_pulse_gen.sv
module spl_pulse_gen
  import spl_pkg::*;
#(
  parameter int unsigned LEN_W = 4,
  parameter int unsigned GAP   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             pulse_o
);
  localparam int unsigned GAP_W    = (GAP < 2) ? 1 : $clog2(GAP);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP - 1);

  line_state_e      st_q;
  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] pend_q;
  logic [GAP_W-1:0] gap_q;
  logic [LEN_W-1:0] merged;

  assign merged = (req_len_i > pend_q) ? req_len_i : pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      pend_q <= '0;
      gap_q  <= '0;
    end else begin
      case (st_q)
        ST_HIGH: begin
          if (req_len_i > rem_q) begin
            rem_q <= req_len_i - 1'b1;
          end else if (rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
          end else begin
            pend_q <= '0;
            if (GAP_LOAD != '0) begin
              st_q  <= ST_GAP;
              gap_q <= GAP_LOAD;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_GAP: begin
          pend_q <= merged;
          gap_q  <= gap_q - 1'b1;
          if (gap_q == GAP_W'(1)) st_q <= ST_IDLE;
        end
        default: begin
          if (merged != '0) begin
            st_q   <= ST_HIGH;
            rem_q  <= merged - 1'b1;
            pend_q <= '0;
          end
        end
      endcase
    end
  end

  assign pulse_o = (st_q == ST_HIGH);

  AST_GAP_LOW: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_GAP) |=> !pulse_o); // R7
  AST_NO_SHORTEN: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && rem_q != '0) |=> pulse_o); // R6
  AST_START_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && req_len_i != '0) |=> pulse_o); // R2
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && req_len_i == '0 && pend_q == '0) |=> !pulse_o); // R3
endmodule

// File: rtl/spl_encoder.sv
module spl_encoder
  import spl_pkg::*;
#(
  parameter int unsigned NUM_SUB = DEF_NUM_SUB,
  parameter int unsigned LEN_W   = DEF_LEN_W,
  parameter int unsigned SYNC    = DEF_SYNC,
  parameter int unsigned GAP     = DEF_GAP
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SUB-1:0]       hit_i,
  input  logic [NUM_SUB*LEN_W-1:0] len_cfg_i,
  output logic                     pulse_o
);
  logic [NUM_SUB-1:0] rise;
  logic [LEN_W-1:0]   req_len;

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_sync
    spl_edge_sync #(.STAGES(SYNC)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .din    (hit_i[g]),
      .rise_o (rise[g])
    );

    AST_MAX_COVERS: assert property (@(posedge clk) disable iff (rst)
      rise[g] |-> (req_len >= len_cfg_i[g*LEN_W +: LEN_W])); // R4
  end

  spl_max_sel #(.NUM_SUB(NUM_SUB), .LEN_W(LEN_W)) u_max (
    .rise_i (rise),
    .len_i  (len_cfg_i),
    .max_o  (req_len)
  );

  spl_pulse_gen #(.LEN_W(LEN_W), .GAP(GAP)) u_gen (
    .clk       (clk),
    .rst       (rst),
    .req_len_i (req_len),
    .pulse_o   (pulse_o)
  );
endmodule

// File: tb/tb_spl_encoder.sv
module tb_spl_encoder;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  hit = '0;
  logic [11:0] cfg = '0;
  logic        pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  spl_encoder dut (
    .clk       (clk),
    .rst       (rst),
    .hit_i     (hit),
    .len_cfg_i (cfg),
    .pulse_o   (pulse)
  );

  typedef struct packed {
    logic [2:0] m;
    logic [3:0] l0;
    logic [3:0] l1;
    logic [3:0] l2;
    logic [4:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'b001, 4'd3,  4'd7, 4'd12, 5'd3},
    '{3'b010, 4'd3,  4'd7, 4'd12, 5'd7},
    '{3'b100, 4'd3,  4'd7, 4'd12, 5'd12},
    '{3'b011, 4'd3,  4'd7, 4'd12, 5'd7},
    '{3'b101, 4'd3,  4'd7, 4'd12, 5'd12},
    '{3'b111, 4'd3,  4'd7, 4'd12, 5'd12},
    '{3'b110, 4'd3,  4'd7, 4'd12, 5'd12},
    '{3'b010, 4'd5,  4'd0, 4'd9,  5'd0},
    '{3'b011, 4'd5,  4'd0, 4'd9,  5'd5},
    '{3'b010, 4'd15, 4'd1, 4'd2,  5'd1},
    '{3'b001, 4'd15, 4'd1, 4'd2,  5'd15},
    '{3'b111, 4'd15, 4'd1, 4'd2,  5'd15}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int first_hi(input logic [63:0] t);
    for (int k = 0; k < 64; k++) if (t[k]) return k;
    return -1;
  endfunction

  function automatic int cnt_hi(input logic [63:0] t);
    int c = 0;
    for (int k = 0; k < 64; k++) if (t[k]) c++;
    return c;
  endfunction

  function automatic int segs(input logic [63:0] t);
    int c = 0;
    for (int k = 1; k < 64; k++) if (t[k] && !t[k-1]) c++;
    return c;
  endfunction

  // Sample index k sees the output after the k-th posedge following the drive at k=0.
  task automatic run(input logic [2:0] ma, input int hold_a,
                     input logic [2:0] mb, input int off_b, input int hold_b,
                     output logic [63:0] tr);
    tr = '0;
    for (int k = 0; k < 48; k++) begin
      @(negedge clk);
      tr[k] = pulse;
      hit = ((k < hold_a) ? ma : 3'b000) |
            ((k >= off_b && k < off_b + hold_b) ? mb : 3'b000);
    end
    hit = '0;
  endtask

  initial begin : watchdog
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] tr;
    int dec;
    cfg = {4'd12, 4'd7, 4'd3};
    // R1: low in reset and just after
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(pulse == 1'b0, "R1 in reset", pulse, 0);
    end
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(pulse == 1'b0, "R1 after reset", pulse, 0);
    end

    // Table walk: R2 R3 R4 R9
    for (int v = 0; v < NV; v++) begin
      cfg = {VECS[v].l2, VECS[v].l1, VECS[v].l0};
      run(VECS[v].m, 2, 3'b000, 0, 0, tr);
      chk(cnt_hi(tr) == int'(VECS[v].exp), "R2/R3/R4 length", cnt_hi(tr), VECS[v].exp);
      if (VECS[v].exp != 0) begin
        chk(first_hi(tr) == 3, "R2 latency", first_hi(tr), 3);
        chk(segs(tr) == 1, "R2 single pulse", segs(tr), 1);
      end
      if ($countones(VECS[v].m) == 1 && VECS[v].exp != 0) begin
        dec = -1;
        for (int i = 0; i < 3; i++) if (int'(cfg[i*4 +: 4]) == cnt_hi(tr)) dec = i;
        for (int i = 0; i < 3; i++) if (VECS[v].m[i]) chk(dec == i, "R9 decode", dec, i);
      end
    end

    // R8: held input gives one pulse
    cfg = {4'd2, 4'd9, 4'd6};
    run(3'b001, 30, 3'b000, 0, 0, tr);
    chk(segs(tr) == 1, "R8 pulses", segs(tr), 1);
    chk(cnt_hi(tr) == 6, "R8 length", cnt_hi(tr), 6);

    // R5: longer hit mid-pulse extends
    cfg = {4'd2, 4'd10, 4'd4};
    run(3'b001, 2, 3'b010, 2, 2, tr);
    chk(cnt_hi(tr) == 12, "R5 extend", cnt_hi(tr), 12);
    chk(segs(tr) == 1, "R5 one pulse", segs(tr), 1);

    // R5: hit landing on last high cycle merges
    cfg = {4'd0, 4'd5, 4'd3};
    run(3'b001, 2, 3'b010, 3, 2, tr);
    chk(cnt_hi(tr) == 8, "R5 last-cycle extend", cnt_hi(tr), 8);
    chk(segs(tr) == 1, "R5 last-cycle one pulse", segs(tr), 1);

    // R6: shorter hits never shorten
    cfg = {4'd2, 4'd4, 4'd10};
    run(3'b001, 2, 3'b100, 2, 2, tr);
    chk(cnt_hi(tr) == 10, "R6 short early", cnt_hi(tr), 10);
    run(3'b001, 2, 3'b010, 4, 2, tr);
    chk(cnt_hi(tr) == 10, "R6 short later", cnt_hi(tr), 10);

    // R7: hit in the gap is deferred past two low cycles
    cfg = {4'd0, 4'd5, 4'd3};
    run(3'b001, 2, 3'b010, 4, 2, tr);
    chk(segs(tr) == 2, "R7 two pulses", segs(tr), 2);
    chk(tr[7:6] == 2'b00, "R7 gap low", int'(tr[7:6]), 0);
    chk(tr[8] == 1'b1, "R7 deferred start", int'(tr[8]), 1);
    chk(cnt_hi(tr) == 8, "R7 total high", cnt_hi(tr), 8);

    // R3: disabled sub-pixel alone
    cfg = {4'd7, 4'd0, 4'd7};
    run(3'b010, 2, 3'b000, 0, 0, tr);
    chk(cnt_hi(tr) == 0, "R3 disabled", cnt_hi(tr), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule